// File: doc/BRIEF.md
# Wide Access Bus Splitter

This block takes one 16-bit or 32-bit data or I/O access at any byte address and carries it out on a bus that moves 16 bits per cycle. It works out how many bus cycles the access needs: one, two or three. For each cycle it presents a word address and a separate enable for each of the two byte lanes. On writes it places each byte of the access on the lane that its address selects. On reads it collects the bytes that come back and puts them together into one little-endian result.

The cycle sequencer in front of the bus runs the handshake. It acknowledges each presented cycle with a one-clock ready. From the moment the first cycle is presented until the last one is acknowledged, the splitter raises a hold-block flag. The hold arbiter uses this flag to defer a bus hold request until the whole transfer has finished. The sequence is locked only inside the chip: the block has no external lock output and never drives one.

Top module: `wide_split`

## Requirements
- R1: A 16-bit access at an even address uses one bus cycle. That cycle uses word address A>>1 with both byte enables set.
- R2: A 16-bit access at an odd address uses two cycles. The first cycle is at word A>>1 with only the high enable set. The second is at the next word with only the low enable set.
- R3: A 32-bit access at an even address uses two cycles with both enables set, at word A>>1 and at the word after it.
- R4: A 32-bit access at an odd address uses three cycles: high enable only at word A>>1, then both enables at the next word, then low enable only at the word after that.
- R5: Byte j of the write data (bits 8j+7..8j) is driven on the lane given by bit 0 of address A+j. Bit 0 = 0 selects the low lane (cyc_wdata[7:0]) and bit 0 = 1 selects the high lane (cyc_wdata[15:8]). This happens in the cycle whose word address equals (A+j)>>1. A lane whose enable is clear is driven with zeros.
- R6: On a read, byte j of acc_rdata is the byte returned for address A+j. Returned bytes on lanes whose enable is clear are discarded. For a 16-bit read, acc_rdata[31:16] is zero.
- R7: acc_done is high for exactly one clock, in the cycle after the edge where cyc_ready acknowledges the final cycle. acc_rdata holds the result in that cycle.
- R8: cyc_valid and hold_block rise in the cycle after an accepted acc_start. They stay high, with the address, enables and write data held steady, until the edge where the final cycle is acknowledged. Then they fall together.
- R9: acc_start while a transfer is in progress is ignored. cyc_ready while no cycle is presented is ignored.
- R10: After reset, cyc_valid, hold_block, acc_done, cyc_write, cyc_be_hi, cyc_be_lo, cyc_addr and acc_rdata are all zero.
- R11: cyc_write is high during every cycle of a write access and low during every cycle of a read access.
- R12: Word addresses wrap modulo 2^(ADDR_W-1). A transfer that starts at the top byte address continues at word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_start | input | 1 | Start an access (accepted only when idle) |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 32 | Write data, byte 0 in bits 7..0 |
| acc_rdata | output | 32 | Assembled read result |
| acc_done | output | 1 | One-clock completion pulse |
| hold_block | output | 1 | Transfer in progress, hold must wait |
| cyc_valid | output | 1 | A bus cycle is being presented |
| cyc_addr | output | ADDR_W-1 | Word address of the cycle |
| cyc_be_hi | output | 1 | High byte lane enable |
| cyc_be_lo | output | 1 | Low byte lane enable |
| cyc_write | output | 1 | Direction of the cycle |
| cyc_wdata | output | 16 | Write data lanes |
| cyc_rdata | input | 16 | Read data lanes |
| cyc_ready | input | 1 | Sequencer acknowledges the presented cycle |

## Verification
The sweep covers every combination of the two lowest address bits, both access sizes and both directions. This separates the one-, two- and three-cycle shapes, and the odd-address layouts from the even-address ones. Three address bases are used: zero, a mid-range value and the top of the address space. The top base catches a missed carry into the word address and a missed wrap at the end of memory. The bus model returns distinct data on both lanes, even the lane that is disabled, so a read that keeps a stray lane produces a wrong result. Acknowledgements come after zero, one or two wait clocks, which shows that the presented cycle is held steady and that a start request arriving mid-transfer changes nothing.

// File: rtl/wsplit_pkg.sv
// Shared constants and helpers for the wide access splitter.
// Assumes a 16-bit bus word and accesses of at most four bytes.
package wsplit_pkg;
    localparam int LANE_BYTES = 2;
    localparam int MAX_BYTES  = 4;
    localparam int IDX_W      = 2;

    // Number of bus cycles needed for an access of nbytes at offset a0.
    function automatic logic [IDX_W-1:0] cycle_total(input logic a0, input logic wide);
        int nbytes;
        nbytes = wide ? MAX_BYTES : LANE_BYTES;
        cycle_total = IDX_W'((int'(a0) + nbytes + 1) / LANE_BYTES);
    endfunction
endpackage

// File: rtl/wsplit_plan.sv
// Alignment decode: from the low address bit and the size, gives the
// index of the last bus cycle of the access. Purely combinational.
module wsplit_plan
    import wsplit_pkg::*;
(
    input  logic             a0,
    input  logic             wide,
    output logic [IDX_W-1:0] last_idx
);
    // Last index is the cycle count minus one.
    always_comb begin
        last_idx = cycle_total(a0, wide) - IDX_W'(1);
    end
endmodule

// File: rtl/wsplit_lane.sv
// Lane mapper: for bus cycle idx, finds which access byte (if any)
// each byte lane carries, sets the enables and steers write data.
// Assumes idx never exceeds the last index of the access.
module wsplit_lane
    import wsplit_pkg::*;
(
    input  logic [IDX_W-1:0]     idx,
    input  logic                 a0,
    input  logic                 wide,
    input  logic [8*MAX_BYTES-1:0] wdata,
    output logic                 en_lo,
    output logic                 en_hi,
    output logic [1:0]           sel_lo,
    output logic [1:0]           sel_hi,
    output logic [15:0]          lane_wdata
);
    int j_lo;
    int j_hi;
    int nbytes;

    // Byte index per lane is 2*idx - a0 (low) and one more (high).
    always_comb begin
        nbytes     = wide ? MAX_BYTES : LANE_BYTES;
        j_lo       = LANE_BYTES * int'(idx) - int'(a0);
        j_hi       = j_lo + 1;
        en_lo      = (j_lo >= 0) && (j_lo < nbytes);
        en_hi      = (j_hi >= 0) && (j_hi < nbytes);
        sel_lo     = 2'(j_lo);
        sel_hi     = 2'(j_hi);
        lane_wdata = '0;
        if (en_lo) lane_wdata[7:0]  = wdata[8*sel_lo +: 8];
        if (en_hi) lane_wdata[15:8] = wdata[8*sel_hi +: 8];
    end
endmodule

// File: rtl/wsplit_merge.sv
// Read assembler: one byte register per access byte; each is loaded
// from the lane that carries it and cleared when a new access starts.
module wsplit_merge
    import wsplit_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   capture,
    input  logic                   en_lo,
    input  logic                   en_hi,
    input  logic [1:0]             sel_lo,
    input  logic [1:0]             sel_hi,
    input  logic [15:0]            lane_rdata,
    output logic [8*MAX_BYTES-1:0] result
);
    for (genvar b = 0; b < MAX_BYTES; b++) begin : g_byte
        // Load this byte from whichever enabled lane maps to it.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                result[8*b +: 8] <= '0;
            end else if (capture && en_lo && sel_lo == 2'(b)) begin
                result[8*b +: 8] <= lane_rdata[7:0];
            end else if (capture && en_hi && sel_hi == 2'(b)) begin
                result[8*b +: 8] <= lane_rdata[15:8];
            end
        end
    end
endmodule

// File: rtl/wide_split.sv
// Wide access bus splitter top. Accepts one access when idle, presents
// its bus cycles one at a time, advances on each cyc_ready and pulses
// acc_done after the last. hold_block covers the whole sequence so no
// bus hold can be granted between its cycles.
module wide_split
    import wsplit_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   acc_start,
    input  logic [ADDR_W-1:0]      acc_addr,
    input  logic                   acc_wide,
    input  logic                   acc_write,
    input  logic [8*MAX_BYTES-1:0] acc_wdata,
    output logic [8*MAX_BYTES-1:0] acc_rdata,
    output logic                   acc_done,
    output logic                   hold_block,
    output logic                   cyc_valid,
    output logic [ADDR_W-2:0]      cyc_addr,
    output logic                   cyc_be_hi,
    output logic                   cyc_be_lo,
    output logic                   cyc_write,
    output logic [15:0]            cyc_wdata,
    input  logic [15:0]            cyc_rdata,
    input  logic                   cyc_ready
);
    localparam int WA_W = ADDR_W - 1;

    logic                   busy_q;
    logic                   done_q;
    logic [IDX_W-1:0]       idx_q;
    logic [ADDR_W-1:0]      addr_q;
    logic                   wide_q;
    logic                   write_q;
    logic [8*MAX_BYTES-1:0] wdata_q;
    logic [IDX_W-1:0]       last_idx;
    logic                   en_lo, en_hi;
    logic [1:0]             sel_lo, sel_hi;
    logic [15:0]            lane_wdata;
    logic                   accept;
    logic                   ack;

    assign accept = acc_start && !busy_q;
    assign ack    = cyc_ready && busy_q;

    wsplit_plan u_plan (
        .a0       (addr_q[0]),
        .wide     (wide_q),
        .last_idx (last_idx)
    );

    wsplit_lane u_lane (
        .idx        (idx_q),
        .a0         (addr_q[0]),
        .wide       (wide_q),
        .wdata      (wdata_q),
        .en_lo      (en_lo),
        .en_hi      (en_hi),
        .sel_lo     (sel_lo),
        .sel_hi     (sel_hi),
        .lane_wdata (lane_wdata)
    );

    wsplit_merge u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .capture    (ack && !write_q),
        .en_lo      (en_lo),
        .en_hi      (en_hi),
        .sel_lo     (sel_lo),
        .sel_hi     (sel_hi),
        .lane_rdata (cyc_rdata),
        .result     (acc_rdata)
    );

    // Sequencing: latch on accept, step on ack, finish on last ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            idx_q   <= '0;
            addr_q  <= '0;
            wide_q  <= 1'b0;
            write_q <= 1'b0;
            wdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                busy_q  <= 1'b1;
                idx_q   <= '0;
                addr_q  <= acc_addr;
                wide_q  <= acc_wide;
                write_q <= acc_write;
                wdata_q <= acc_wdata;
            end else if (ack) begin
                if (idx_q == last_idx) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    idx_q <= idx_q + IDX_W'(1);
                end
            end
        end
    end

    // Bus-side outputs, forced to zero while idle.
    always_comb begin
        cyc_valid  = busy_q;
        hold_block = busy_q;
        acc_done   = done_q;
        cyc_addr   = busy_q ? (addr_q[ADDR_W-1:1] + WA_W'(idx_q)) : '0;
        cyc_be_lo  = busy_q && en_lo;
        cyc_be_hi  = busy_q && en_hi;
        cyc_write  = busy_q && write_q;
        cyc_wdata  = busy_q ? lane_wdata : '0;
    end
endmodule

// File: rtl/wide_split_chk.sv
// Protocol checker for wide_split, attached by bind. Observes ports only.
module wide_split_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_start,
    input logic              acc_done,
    input logic              cyc_valid,
    input logic              cyc_ready,
    input logic              cyc_be_hi,
    input logic              cyc_be_lo,
    input logic [ADDR_W-2:0] cyc_addr,
    input logic [15:0]       cyc_wdata
);
    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |=> !acc_done);

    // R7
    done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |-> $past(cyc_valid && cyc_ready));

    // R8
    hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && !cyc_ready) |=> (cyc_valid && $stable(cyc_addr) && $stable(cyc_wdata)));

    // R8
    start_before_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cyc_valid) |-> $past(acc_start));

    // R5
    lane_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |-> (cyc_be_hi || cyc_be_lo));

    // R5
    idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && !cyc_be_lo) |-> (cyc_wdata[7:0] == 8'h00));

    // R12
    word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_ready) |=> (!cyc_valid || cyc_addr == $past(cyc_addr) + 1'b1));
endmodule

bind wide_split wide_split_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_start (acc_start),
    .acc_done  (acc_done),
    .cyc_valid (cyc_valid),
    .cyc_ready (cyc_ready),
    .cyc_be_hi (cyc_be_hi),
    .cyc_be_lo (cyc_be_lo),
    .cyc_addr  (cyc_addr),
    .cyc_wdata (cyc_wdata)
);

// File: tb/tb_wide_split.sv
// Sweep bench: every low-address offset, both sizes, both directions,
// three address bases, varying wait clocks. Expected values derive from
// the byte address of each access byte.
module tb_wide_split;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_start = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic          acc_wide = 1'b0;
    logic          acc_write = 1'b0;
    logic [31:0]   acc_wdata = '0;
    logic [31:0]   acc_rdata;
    logic          acc_done;
    logic          hold_block;
    logic          cyc_valid;
    logic [AW-2:0] cyc_addr;
    logic          cyc_be_hi;
    logic          cyc_be_lo;
    logic          cyc_write;
    logic [15:0]   cyc_wdata;
    logic [15:0]   cyc_rdata = '0;
    logic          cyc_ready = 1'b0;

    int vecs = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wide_split #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .acc_start(acc_start), .acc_addr(acc_addr),
        .acc_wide(acc_wide), .acc_write(acc_write), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_done(acc_done), .hold_block(hold_block),
        .cyc_valid(cyc_valid), .cyc_addr(cyc_addr), .cyc_be_hi(cyc_be_hi),
        .cyc_be_lo(cyc_be_lo), .cyc_write(cyc_write), .cyc_wdata(cyc_wdata),
        .cyc_rdata(cyc_rdata), .cyc_ready(cyc_ready)
    );

    function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
        return a[7:0] * 8'd37 + a[15:8] + a[23:16] * 8'd3 + 8'd5;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access, presented and acknowledged cycle by cycle.
    task automatic run(input logic [AW-1:0] a, input logic wide, input logic wr,
                       input logic [31:0] d, input int waits, input bit poke);
        int            nb;
        int            ncyc;
        logic [AW-2:0] wi;
        logic [AW-1:0] ab;
        logic [31:0]   exp_r;
        logic          eh, el;
        logic [15:0]   ew;
        string         shape;
        nb    = wide ? 4 : 2;
        ncyc  = (int'(a[0]) + nb + 1) / 2;
        shape = !wide ? (a[0] ? "R2" : "R1") : (a[0] ? "R4" : "R3");
        exp_r = '0;
        for (int j = 0; j < nb; j++) begin
            ab = a + AW'(j);
            exp_r[8*j +: 8] = mem_byte(ab);
        end
        @(negedge clk);
        acc_start = 1'b1; acc_addr = a; acc_wide = wide; acc_write = wr; acc_wdata = d;
        @(negedge clk);
        acc_start = 1'b0; acc_addr = ~a; acc_wdata = ~d; acc_wide = ~wide;
        chk("R8 valid after start", {30'd0, cyc_valid, hold_block}, 32'd3);
        for (int i = 0; i < ncyc; i++) begin
            wi = a[AW-1:1] + (AW-1)'(i);
            eh = 1'b0; el = 1'b0; ew = '0;
            for (int j = 0; j < nb; j++) begin
                ab = a + AW'(j);
                if (ab[AW-1:1] == wi) begin
                    if (ab[0]) begin eh = 1'b1; ew[15:8] = d[8*j +: 8]; end
                    else       begin el = 1'b1; ew[7:0]  = d[8*j +: 8]; end
                end
            end
            for (int w = 0; w <= waits; w++) begin
                chk({shape, " R12 word address"}, 32'(cyc_addr), 32'(wi));
                chk({shape, " byte enables"}, {30'd0, cyc_be_hi, cyc_be_lo}, {30'd0, eh, el});
                chk("R5 write lanes", 32'(cyc_wdata), 32'(ew));
                chk("R11 direction", 32'(cyc_write), 32'(wr));
                chk("R8 busy/valid", {30'd0, cyc_valid, hold_block}, 32'd3);
                chk("R7 no early done", 32'(acc_done), 32'd0);
                if (w < waits) begin
                    if (poke && i == 0 && w == 0) acc_start = 1'b1; // R9 start while busy
                    @(negedge clk);
                    acc_start = 1'b0;
                end
            end
            cyc_ready = 1'b1;
            cyc_rdata = {mem_byte({wi, 1'b1}), mem_byte({wi, 1'b0})};
            @(negedge clk);
            cyc_ready = 1'b0;
            cyc_rdata = '0;
        end
        chk({shape, " R7 done pulse"}, 32'(acc_done), 32'd1);
        chk("R8 released", {30'd0, cyc_valid, hold_block}, 32'd0);
        if (!wr) chk("R6 read result", acc_rdata, exp_r);
        @(negedge clk);
        chk("R7 done single", 32'(acc_done), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        logic [AW-1:0] bases [3];
        int            k;
        bases[0] = 24'h000000; bases[1] = 24'h5A3C40; bases[2] = 24'hFFFFFC;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 reset flags", {27'd0, cyc_valid, hold_block, acc_done, cyc_write, cyc_be_hi}, 32'd0);
        chk("R10 reset addr", 32'(cyc_addr), 32'd0);
        chk("R10 reset lo enable", 32'(cyc_be_lo), 32'd0);
        chk("R10 reset rdata", acc_rdata, 32'd0);
        // R9 ready while idle
        cyc_ready = 1'b1; cyc_rdata = 16'hBEEF;
        @(negedge clk);
        cyc_ready = 1'b0; cyc_rdata = '0;
        chk("R9 idle ready valid", {30'd0, cyc_valid, acc_done}, 32'd0);
        k = 0;
        for (int b = 0; b < 3; b++) begin
            for (int off = 0; off < 4; off++) begin
                for (int wd = 0; wd < 2; wd++) begin
                    for (int wr = 0; wr < 2; wr++) begin
                        run(bases[b] + AW'(off), wd[0], wr[0],
                            32'hA1B2C3D4 ^ (32'(k) * 32'h01010101), k % 3, (k % 3) != 0);
                        k++;
                    end
                end
            end
        end
        @(negedge clk);
        chk("R9 idle after sweep", 32'(cyc_valid), 32'd0);
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule